// File: doc/BRIEF.md
# Paging Address Translator with Associative Cache

This block turns a logical address into a physical address for a single-level paged memory. The logical address splits in two. The upper bits select a virtual page. The lower bits are an offset that passes through unchanged. A small fully associative translation cache compares the virtual page against every stored entry at once. On a hit, the physical address is the cached frame number with the offset appended.

When the cache has no entry for the page, the unit walks the page table itself. It issues one read on a simple request/response memory port at the table base plus the page number. If the returned entry is marked present, the unit installs it in the cache and answers. Two conditions produce a fault response instead of an address:

- The page number is at or above the table length.
- The fetched entry is marked not present.

A flush input empties the cache, for example on an address-space switch. One translation is in flight at a time. `req_ready` shows when a new one may be accepted.

Top module: `paging_xlate`

## Requirements
- R1: For a logical address, the page number is bits [VA_W-1:OFF_W] and the offset is bits [OFF_W-1:0]. A successful response gives `rsp_paddr` = {frame, offset}, with the offset unchanged.
- R2: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0. The cache is empty, so the first in-range access always reads memory.
- R3: A request accepted (`req_valid` and `req_ready` high at a clock edge) whose in-range page is cached gets `rsp_valid` in the very next cycle, and no memory read is issued.
- R4: On a miss, `req_ready` goes low. `mem_req` is held high with `mem_addr` = `pt_base` + page number (modulo 2^PTA_W), stable until `mem_rvalid`. The response comes in the cycle after `mem_rvalid`.
- R5: A page number greater than or equal to `pt_len` produces `rsp_fault_range` in the next cycle, with no memory read, even if that page is cached.
- R6: A page-table entry holds the present flag in bit FRM_W and the frame number in bits [FRM_W-1:0]. A fetched entry with the flag clear produces `rsp_fault_invalid` and is not cached, so a repeat access reads memory again.
- R7: A fetched present entry is written into the lowest-numbered empty cache slot. When all slots are full, a replacement pointer starting at slot 0 picks the victim and advances by one per such replacement, wrapping after TLB_N-1. Flushing does not move the pointer.
- R8: A one-cycle `flush` pulse empties every cache slot, so each later access misses until it is refetched.
- R9: No page is ever held in two cache slots at once.
- R10: `rsp_valid` is a one-cycle pulse per accepted request. On a fault, exactly one fault flag is set and `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all cache slots |
| pt_base | input | PTA_W | Page-table base address |
| pt_len | input | VPN_W+1 | Number of page-table entries |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | VA_W | Logical address to translate |
| req_ready | output | 1 | Unit can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault_range | output | 1 | Page number out of table range |
| rsp_fault_invalid | output | 1 | Entry marked not present |
| mem_req | output | 1 | Page-table read request, held until answered |
| mem_addr | output | PTA_W | Page-table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | FRM_W+1 | Page-table entry {present, frame} |

## Verification
The bench targets the length boundary: page `pt_len`-1 must translate and page `pt_len` must fault. A comparison that uses `>` instead of `>=` would translate one page too many. It also checks that an already cached page still faults once the length shrinks; a design that consulted the cache first would return a stale address.

Entries marked not present are fetched twice in a row, to show they were never cached; a design that refilled regardless would answer the second access with a bogus hit and no memory read.

Six distinct pages are pushed through the four-slot cache and earlier pages are revisited. A wrong victim choice shows up as an unexpected memory read or a missing one. Accesses after a flush must read memory again. Random traffic with repeated pages, occasional flushes and length changes is compared against a bench model of the cache.

// File: rtl/paging_xlate.sv
module paging_xlate #(
  parameter int VA_W  = 12,
  parameter int OFF_W = 6,
  parameter int PA_W  = 14,
  parameter int PTA_W = 12,
  parameter int TLB_N = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [PTA_W-1:0]          pt_base,
  input  logic [VA_W-OFF_W:0]       pt_len,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_vaddr,
  output logic                      req_ready,
  output logic                      rsp_valid,
  output logic [PA_W-1:0]           rsp_paddr,
  output logic                      rsp_fault_range,
  output logic                      rsp_fault_invalid,
  output logic                      mem_req,
  output logic [PTA_W-1:0]          mem_addr,
  input  logic                      mem_rvalid,
  input  logic [PA_W-OFF_W:0]       mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int FRM_W = PA_W - OFF_W;
  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  typedef enum logic {S_IDLE, S_WAIT} state_t;
  state_t state;

  logic [VPN_W-1:0] tlb_vpn [TLB_N];
  logic [FRM_W-1:0] tlb_frm [TLB_N];
  logic [TLB_N-1:0] tlb_val;
  logic [IDX_W-1:0] rr;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;

  wire [VPN_W-1:0] in_vpn   = req_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] in_off   = req_vaddr[OFF_W-1:0];
  wire             fire     = req_valid && (state == S_IDLE);
  wire             in_range = {1'b0, in_vpn} < pt_len;
  wire             pte_ok   = mem_rdata[FRM_W];

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_WAIT);

  logic [TLB_N-1:0] hit_vec;
  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hit_vec[i] = tlb_val[i] && (tlb_vpn[i] == in_vpn);
  end

  logic [FRM_W-1:0] hit_frm;
  always_comb begin
    hit_frm = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hit_vec[i]) hit_frm = tlb_frm[i];
  end

  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = TLB_N - 1; i >= 0; i--)
      if (!tlb_val[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  wire [IDX_W-1:0] vic_idx = free_any ? free_idx : rr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state             <= S_IDLE;
      tlb_val           <= '0;
      rr                <= '0;
      vpn_q             <= '0;
      off_q             <= '0;
      mem_addr          <= '0;
      rsp_valid         <= 1'b0;
      rsp_paddr         <= '0;
      rsp_fault_range   <= 1'b0;
      rsp_fault_invalid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (fire) begin
          if (!in_range) begin
            rsp_valid         <= 1'b1;
            rsp_paddr         <= '0;
            rsp_fault_range   <= 1'b1;
            rsp_fault_invalid <= 1'b0;
          end else if (|hit_vec) begin
            rsp_valid         <= 1'b1;
            rsp_paddr         <= {hit_frm, in_off};
            rsp_fault_range   <= 1'b0;
            rsp_fault_invalid <= 1'b0;
          end else begin
            state    <= S_WAIT;
            vpn_q    <= in_vpn;
            off_q    <= in_off;
            mem_addr <= pt_base + {{(PTA_W-VPN_W){1'b0}}, in_vpn};
          end
        end
        S_WAIT: if (mem_rvalid) begin
          state             <= S_IDLE;
          rsp_valid         <= 1'b1;
          rsp_fault_range   <= 1'b0;
          rsp_fault_invalid <= !pte_ok;
          rsp_paddr         <= pte_ok ? {mem_rdata[FRM_W-1:0], off_q} : '0;
          if (pte_ok) begin
            tlb_vpn[vic_idx] <= vpn_q;
            tlb_frm[vic_idx] <= mem_rdata[FRM_W-1:0];
            tlb_val[vic_idx] <= 1'b1;
            if (!free_any)
              rr <= (rr == IDX_W'(TLB_N - 1)) ? '0 : rr + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (flush) tlb_val <= '0;
    end
  end

  // R3
  hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_range && |hit_vec) |=> (rsp_valid && !rsp_fault_range && !rsp_fault_invalid));

  // R5
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_range) |=> (rsp_valid && rsp_fault_range && rsp_paddr == '0));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && !req_ready));

  // R6
  invalid_pte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && !pte_ok) |=> (rsp_valid && rsp_fault_invalid));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tlb_val == '0));

  // R9
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10
  one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_fault_range, rsp_fault_invalid}) <= 1) && !$past(rsp_valid));
endmodule

// File: tb/tb_paging_xlate.sv
module tb_paging_xlate;
  localparam int CLK_P = 10;
  localparam int VA_W = 12, OFF_W = 6, PA_W = 14, PTA_W = 12, TLB_N = 4;
  localparam int VPN_W = VA_W - OFF_W, FRM_W = PA_W - OFF_W;

  logic clk = 0, rst_n = 0, flush = 0, req_valid = 0, mem_rvalid = 0;
  logic [PTA_W-1:0] pt_base = '0;
  logic [VPN_W:0]   pt_len = '0;
  logic [VA_W-1:0]  req_vaddr = '0;
  logic [FRM_W:0]   mem_rdata = '0;
  logic req_ready, rsp_valid, rsp_fault_range, rsp_fault_invalid, mem_req;
  logic [PA_W-1:0]  rsp_paddr;
  logic [PTA_W-1:0] mem_addr;

  paging_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTA_W(PTA_W), .TLB_N(TLB_N)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base), .pt_len(pt_len),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault_range(rsp_fault_range),
    .rsp_fault_invalid(rsp_fault_invalid), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  initial forever #(CLK_P/2) clk = ~clk;

  int errors = 0, checks = 0, mem_count = 0;
  logic [PTA_W-1:0] exp_maddr;

  logic [VPN_W-1:0] m_vpn [TLB_N];
  logic [FRM_W-1:0] m_frm [TLB_N];
  logic             m_val [TLB_N];
  int               m_rr = 0;

  function automatic logic [FRM_W:0] pte_at(input logic [PTA_W-1:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd37 + 16'd5;
    pte_at = {(16'(a) * 16'd7) % 16'd5 != 16'd0, t[FRM_W-1:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_rvalid) begin
        chk(mem_addr == exp_maddr, "R4 mem_addr", mem_addr, exp_maddr);
        mem_count++;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(mem_req == 1'b1, "R4 mem_req held", mem_req, 1);
        mem_rdata  = pte_at(mem_addr);
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic model_flush();
    for (int i = 0; i < TLB_N; i++) m_val[i] = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_flush();
  endtask

  task automatic xlate(input logic [VA_W-1:0] va);
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    logic [FRM_W:0]   pte;
    bit hit, rng, miss;
    int hidx, m0, cyc, slot;
    logic [PA_W-1:0] exp_pa;
    vpn = va[VA_W-1:OFF_W];
    off = va[OFF_W-1:0];
    rng = ({1'b0, vpn} >= pt_len);
    hit = 0; hidx = 0;
    for (int i = 0; i < TLB_N; i++) if (m_val[i] && m_vpn[i] == vpn) begin hit = 1; hidx = i; end
    miss = !rng && !hit;
    exp_maddr = pt_base + PTA_W'(vpn);
    pte = pte_at(exp_maddr);
    if (rng) exp_pa = '0;
    else if (hit) exp_pa = {m_frm[hidx], off};
    else exp_pa = pte[FRM_W] ? {pte[FRM_W-1:0], off} : '0;
    m0 = mem_count;
    chk(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 50) begin @(negedge clk); cyc++; end
    chk(rsp_paddr == exp_pa, "R1 paddr", rsp_paddr, exp_pa);
    chk(rsp_fault_range == rng, "R5 range fault", rsp_fault_range, rng);
    chk(rsp_fault_invalid == (miss && !pte[FRM_W]), "R6 invalid fault", rsp_fault_invalid, miss && !pte[FRM_W]);
    if (miss) begin
      chk(cyc >= 2, "R4 miss latency", cyc, 2);
      chk(mem_count - m0 == 1, "R7 miss reads memory once", mem_count - m0, 1);
    end else begin
      chk(cyc == 1, "R3 hit/range latency", cyc, 1);
      chk(mem_count == m0, "R3 no memory read", mem_count - m0, 0);
    end
    if (miss && pte[FRM_W]) begin
      slot = -1;
      for (int i = TLB_N - 1; i >= 0; i--) if (!m_val[i]) slot = i;
      if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % TLB_N; end
      m_vpn[slot] = vpn; m_frm[slot] = pte[FRM_W-1:0]; m_val[slot] = 1'b1;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 single pulse", rsp_valid, 0);
  endtask

  function automatic logic [VA_W-1:0] va_of(input int vpn, input int off);
    va_of = {VPN_W'(vpn), OFF_W'(off)};
  endfunction

  initial begin
    repeat (CLK_P * 10000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed1234);
    model_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(req_ready == 1'b1, "R2 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R2 rsp_valid", rsp_valid, 0);
    chk(mem_req == 1'b0, "R2 mem_req", mem_req, 0);
    pt_base = 12'h100;
    pt_len  = 7'd40;
    xlate(va_of(3, 5));          // R2 first access misses
    xlate(va_of(3, 6'h3f));      // R3 hit, R1 offset
    xlate(va_of(39, 1));         // R5 last in-range page
    xlate(va_of(40, 2));         // R5 boundary fault
    xlate(va_of(63, 0));         // R5
    xlate(va_of(4, 9));          // R6 invalid entry
    xlate(va_of(4, 9));          // R6 not cached
    do_flush();                  // R8
    xlate(va_of(3, 1));          // R8 misses again
    for (int v = 10; v < 16; v++) xlate(va_of(v, v)); // R7 fill and evict
    xlate(va_of(10, 0));         // R7 evicted page
    xlate(va_of(15, 0));         // R9 resident
    xlate(va_of(13, 0));
    pt_len = 7'd5;
    xlate(va_of(15, 0));         // R5 cached page beyond length
    pt_len = 7'd64;
    xlate(va_of(63, 7));         // R5 full length
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 29) == 0) do_flush();
      if ($urandom_range(0, 49) == 0) pt_len = 7'($urandom_range(1, 64));
      if ($urandom_range(0, 3) == 0)
        xlate(va_of($urandom_range(0, 63), $urandom_range(0, 63)));
      else
        xlate(va_of($urandom_range(0, 7), $urandom_range(0, 63)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule